// File: doc/BRIEF.md
# Tiered Ground Fault Trip Timer

This block decides when a ground fault breaker must trip. An upstream measurement stage classifies the differential leakage current into a tier code every clock: zero means below 6 mA, and codes one to nine stand for ever larger leakage bands. The block keeps one elapsed-time counter that runs while any fault tier is present. It latches a trip request once that time reaches the inverse-time limit of the tier currently reported, so a stronger fault trips sooner. A separate fast path trips at once when a very large instantaneous signal persists for a short window. Both paths bypass nothing else and feed the same latch.

While the trip request is latched, the block produces a gate-enable pulse in every mains half cycle. The pulse starts a fixed phase delay after each zero crossing, about 26 degrees at 60 Hz, and ends at the next crossing. All timing is counted in 100 us ticks derived from the clock (2 MHz nominal). A time-scale divisor shortens every fault delay so that the block can be exercised quickly.

Top module: `gf_trip_timer`

## Requirements
- R1: After reset, `trip_o` and `gate_o` are low.
- R2: The tier code `tier_i` maps to these trip limits in 100 us ticks, each divided by `TIME_DIV`: 1 -> 1250, 2 -> 950, 3 -> 750, 4 -> 600, 5 -> 500, 6 -> 400, 7 -> 350, 8 -> 250, 9 -> 200. Codes 10 to 15 use the limit of code 9, and code 0 means no fault.
- R3: With a constant nonzero tier from a cleared elapsed count, `trip_o` stays low for the first limit-2 ticks and is high by limit+2 ticks.
- R4: A rise to a higher tier keeps the elapsed count, so if the count already exceeds the new tier's limit, `trip_o` rises within 4 clocks.
- R5: The elapsed count clears only when the tier code stays zero from one zero-crossing pulse up to and including the next; a shorter dip keeps the count, which freezes during the dip.
- R6: When `over_i` stays high for more than 14/`TIME_DIV` consecutive ticks, `trip_o` rises regardless of tier; shorter pulses have no effect.
- R7: Once high, `trip_o` stays high until reset, whatever the inputs do.
- R8: If `trip_o` is high at a zero-crossing pulse, `gate_o` rises `GATE_DLY` ticks (plus up to one tick and one clock) after that pulse and falls on the clock after the next pulse; `gate_o` is never high while `trip_o` is low.
- R9: A trip latched after a zero crossing produces no gate pulse in the rest of that half cycle; the first pulse comes in the next half cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 2 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| tier_i | input | 4 | Leakage tier code, 0 = no fault, 1..9 ascending bands |
| over_i | input | 1 | Instantaneous overrange comparator level |
| zc_i | input | 1 | One-clock pulse at each mains zero crossing |
| trip_o | output | 1 | Latched trip request |
| gate_o | output | 1 | Gate enable, phase-delayed within each half cycle |

## Verification
The assertions take the zero-crossing input to be a one-clock pulse whose spacing is far longer than the gate phase delay, and the tier code and overrange level to be clean synchronous levels. The stimulus keeps zero crossings strictly periodic at 80 clocks with `GATE_DLY` of 6 two-clock ticks, drives tier codes and overrange pulses only between edges, and draws random tiers, out-of-range codes and overrange pulse lengths that lie clearly on one side of each timing limit, so that tick phase uncertainty never decides an outcome.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int TIER_W       = 4;
  localparam int TIER_TOP     = 9;
  localparam int BASE_MAX     = 1250;
  localparam int OVR_BASE_DEF = 14;

  // Trip limit of a tier in 100 us ticks, before time scaling.
  function automatic int unsigned tier_limit(input logic [TIER_W-1:0] t);
    case (t)
      4'd0:    return 0;
      4'd1:    return 1250;
      4'd2:    return 950;
      4'd3:    return 750;
      4'd4:    return 600;
      4'd5:    return 500;
      4'd6:    return 400;
      4'd7:    return 350;
      4'd8:    return 250;
      default: return 200;
    endcase
  endfunction
endpackage

// File: rtl/trip_tick_gen.sv
module trip_tick_gen #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      always_ff @(posedge clk) tick <= !rst;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
          tick  <= 1'b0;
        end else begin
          tick  <= (cnt_q == CW'(TICK_DIV - 1));
          cnt_q <= (cnt_q == CW'(TICK_DIV - 1)) ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/trip_fault_timer.sv
module trip_fault_timer
  import trip_pkg::*;
#(
  parameter int TIME_DIV = 1,
  parameter int OVR_BASE = OVR_BASE_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              zc,
  input  logic [TIER_W-1:0] tier,
  input  logic              over,
  output logic              trip
);
  localparam int MAX_DLY   = BASE_MAX / TIME_DIV;
  localparam int EW        = $clog2(MAX_DLY + 2);
  localparam int OVR_TICKS = OVR_BASE / TIME_DIV;
  localparam int OW        = $clog2(OVR_TICKS + 2);

  logic [EW-1:0] elapsed_q;
  logic [EW-1:0] cur_dly;
  logic [OW-1:0] ovr_q;
  logic          quiet_q;
  logic          trip_q;
  logic          active;
  logic          fire;

  assign active = (tier != '0);

  always_comb begin
    int unsigned lim;
    lim = tier_limit(tier) / TIME_DIV;
    if (lim == 0) lim = 1;
    cur_dly = EW'(lim);
  end

  assign fire = (active && (elapsed_q >= cur_dly)) || (ovr_q > OW'(OVR_TICKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
      quiet_q   <= 1'b0;
      ovr_q     <= '0;
      trip_q    <= 1'b0;
    end else begin
      if (zc && quiet_q && !active)
        elapsed_q <= '0;
      else if (tick && active && (elapsed_q != '1))
        elapsed_q <= elapsed_q + 1'b1;

      if (active)  quiet_q <= 1'b0;
      else if (zc) quiet_q <= 1'b1;

      if (!over)                        ovr_q <= '0;
      else if (tick && (ovr_q != '1))   ovr_q <= ovr_q + 1'b1;

      if (fire) trip_q <= 1'b1;
    end
  end

  assign trip = trip_q;

  // R7
  trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trip_q |=> trip_q);

  // R5
  quiet_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (zc && quiet_q && !active) |=> (elapsed_q == '0));

  // R4
  elapsed_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !zc) |=> (elapsed_q >= $past(elapsed_q)));

  // R6
  ovr_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q > OW'(OVR_TICKS)) |=> trip_q);
endmodule

// File: rtl/trip_gate_phase.sv
module trip_gate_phase #(
  parameter int GATE_DLY = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic zc,
  input  logic trip,
  output logic gate
);
  localparam int PW = $clog2(GATE_DLY + 1);

  logic [PW-1:0] phase_q;
  logic          armed_q;
  logic          gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
    end else if (zc) begin
      phase_q <= '0;
      armed_q <= trip;
      gate_q  <= 1'b0;
    end else begin
      if (tick && (phase_q != PW'(GATE_DLY)))
        phase_q <= phase_q + 1'b1;
      if (armed_q && (phase_q == PW'(GATE_DLY)))
        gate_q <= 1'b1;
    end
  end

  assign gate = gate_q;

  // R8
  gate_needs_trip_chk: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> trip);

  // R8
  gate_zc_off_chk: assert property (@(posedge clk) disable iff (rst)
    zc |=> !gate_q);

  // R9
  gate_armed_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(armed_q));
endmodule

// File: rtl/gf_trip_timer.sv
module gf_trip_timer
  import trip_pkg::*;
#(
  parameter int TICK_DIV = 200,
  parameter int TIME_DIV = 1,
  parameter int GATE_DLY = 12,
  parameter int OVR_BASE = OVR_BASE_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIER_W-1:0] tier_i,
  input  logic              over_i,
  input  logic              zc_i,
  output logic              trip_o,
  output logic              gate_o
);
  logic tick;
  logic trip;

  trip_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  trip_fault_timer #(.TIME_DIV(TIME_DIV), .OVR_BASE(OVR_BASE)) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .zc  (zc_i),
    .tier(tier_i),
    .over(over_i),
    .trip(trip)
  );

  trip_gate_phase #(.GATE_DLY(GATE_DLY)) u_gate (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .zc  (zc_i),
    .trip(trip),
    .gate(gate_o)
  );

  assign trip_o = trip;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!trip_o && !gate_o));
endmodule

// File: tb/sim_gf_trip_timer.sv
`timescale 1ns/1ps
module sim_gf_trip_timer;
  localparam int TICK_DIV = 2;
  localparam int TIME_DIV = 5;
  localparam int GATE_DLY = 6;
  localparam int HALF     = 80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tier_i = '0;
  logic       over_i = 1'b0;
  logic       zc_i = 1'b0;
  logic       trip_o, gate_o;
  int         tests = 0, fails = 0;
  int         zc_ph = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  gf_trip_timer #(.TICK_DIV(TICK_DIV), .TIME_DIV(TIME_DIV), .GATE_DLY(GATE_DLY)) u0 (
    .clk(clk), .rst(rst), .tier_i(tier_i), .over_i(over_i),
    .zc_i(zc_i), .trip_o(trip_o), .gate_o(gate_o));

  always @(negedge clk) begin
    zc_ph <= (zc_ph == HALF - 1) ? 0 : zc_ph + 1;
    zc_i  <= (zc_ph == HALF - 1);
  end

  function automatic int exp_limit(input int code);
    int ms10;
    if (code >= 9)      ms10 = 200;
    else if (code == 8) ms10 = 250;
    else if (code == 7) ms10 = 350;
    else if (code == 6) ms10 = 400;
    else if (code == 5) ms10 = 500;
    else if (code == 4) ms10 = 600;
    else if (code == 3) ms10 = 750;
    else if (code == 2) ms10 = 950;
    else                ms10 = 1250;
    return ms10 / TIME_DIV;
  endfunction

  task automatic chk(input string what, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_zc();
    do begin @(negedge clk); #1; end while (!zc_i);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tier_i = '0; over_i = 1'b0;
    wait_clk(3);
    rst = 1'b0;
  endtask

  task automatic tier_trial(input int code);
    int lim;
    lim = exp_limit(code);
    do_reset();
    tier_i = 4'(code);
    wait_clk((lim - 2) * TICK_DIV);
    chk($sformatf("R3 code %0d still low before limit", code), trip_o, 1'b0);
    wait_clk(4 * TICK_DIV + 2);
    chk($sformatf("R2 R3 code %0d tripped after limit", code), trip_o, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    // R1
    chk("R1 trip after reset", trip_o, 1'b0);
    chk("R1 gate after reset", gate_o, 1'b0);

    // R2 R3: directed extremes, out-of-range code, random tiers
    tier_trial(1);
    tier_trial(9);
    tier_trial(13);
    for (int i = 0; i < 5; i++) tier_trial(1 + int'($urandom_range(8)));

    // R4: upward tier keeps elapsed count
    do_reset();
    tier_i = 4'd1;
    wait_clk(100 * TICK_DIV);
    chk("R4 low tier not yet tripped", trip_o, 1'b0);
    tier_i = 4'd9;
    wait_clk(4);
    chk("R4 upward tier trips at once", trip_o, 1'b1);

    // R5: full quiet half cycle clears the count
    do_reset();
    tier_i = 4'd1;
    wait_clk(200 * TICK_DIV);
    tier_i = 4'd0;
    wait_clk(2 * HALF + 4);
    tier_i = 4'd1;
    wait_clk(240 * TICK_DIV);
    chk("R5 count cleared by quiet half cycle", trip_o, 1'b0);
    wait_clk(26);
    chk("R5 trips after full limit from cleared count", trip_o, 1'b1);

    // R5: short dip keeps the count
    do_reset();
    tier_i = 4'd1;
    wait_clk(200 * TICK_DIV);
    tier_i = 4'd0;
    wait_clk(10);
    tier_i = 4'd1;
    wait_clk(90);
    chk("R5 dip not yet at limit", trip_o, 1'b0);
    wait_clk(30);
    chk("R5 dip kept count", trip_o, 1'b1);

    // R6: short overrange pulses ignored, long one trips
    do_reset();
    for (int i = 0; i < 20; i++) begin
      over_i = 1'b1;
      wait_clk(1 + int'($urandom_range(3)));
      over_i = 1'b0;
      wait_clk(6);
    end
    chk("R6 short overrange pulses ignored", trip_o, 1'b0);
    chk("R6 no gate without trip", gate_o, 1'b0);
    over_i = 1'b1;
    wait_clk(8 + int'($urandom_range(8)));
    over_i = 1'b0;
    wait_clk(2);
    chk("R6 long overrange trips", trip_o, 1'b1);

    // R7: latch holds with inputs idle
    wait_clk(3 * HALF);
    chk("R7 trip held", trip_o, 1'b1);

    // R8: gate phase within a half cycle
    wait_zc();
    wait_clk(8);
    chk("R8 gate low before phase delay", gate_o, 1'b0);
    wait_clk(8);
    chk("R8 gate high after phase delay", gate_o, 1'b1);
    wait_zc();
    wait_clk(1);
    chk("R8 gate released at zero crossing", gate_o, 1'b0);
    wait_clk(15);
    chk("R8 gate repeats next half cycle", gate_o, 1'b1);

    // R9: trip latched mid half cycle waits for next crossing
    do_reset();
    chk("R1 trip cleared by reset", trip_o, 1'b0);
    wait_zc();
    wait_clk(30);
    over_i = 1'b1;
    wait_clk(12);
    over_i = 1'b0;
    wait_clk(2);
    chk("R9 trip latched mid half cycle", trip_o, 1'b1);
    begin
      logic seen;
      seen = 1'b0;
      do begin
        @(negedge clk); #1;
        if (gate_o) seen = 1'b1;
      end while (!zc_i);
      chk("R9 no gate in half cycle of trip", seen, 1'b0);
    end
    wait_clk(16);
    chk("R9 gate in following half cycle", gate_o, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule